// File: doc/BRIEF.md
# Serial Command Relay Controller

This block drives a small bank of relays from two sources. The first is an asynchronous serial line, which normally comes from a carrier tone detector and carries one-byte commands. The block oversamples that line at sixteen times the bit rate and takes each bit at its centre. It decodes every good byte against a fixed table: one group of codes switches a single relay on, a second group switches a single relay off, and every other code is ignored. The second source is a row of local push switches. They are active low, and each one flips the state of its own relay.

The two sources act on one shared relay register. A decoded byte always wins a cycle in which both want to act. After each local flip, the switches are locked out for half a second so that a held key does not chatter the relay. When several switches are closed together, only the lowest-numbered one is served, and only one switch is served per lockout window. A one-cycle strobe marks every accepted byte, whether or not its code moves a relay.

Top module: `relay_link_ctrl`

## Requirements
- R1: The serial input is idle high and carries 8 data bits, least significant bit first, with no parity. Each frame opens with one low start bit and ends with one high stop bit. The bit time is 16 ticks of CLK_HZ/(BAUD*16) clock cycles each.
- R2: When the input falls, the receiver checks it again 8 ticks later. If the line has returned high by then, the event is dropped: no strobe and no relay change.
- R3: A frame whose stop bit samples low is discarded. It raises no strobe and leaves every relay unchanged.
- R4: For each accepted byte, strobe_o is high for exactly one cycle. The relay action takes effect at the rising edge numbered 152*DIV+4 after the last rising edge before the start bit falls, where DIV = CLK_HZ/(BAUD*16). strobe_o is high during the cycle just before that edge.
- R5: Codes 0x01, 0x02, 0x03 and 0x04 set relay_o[0], [1], [2] and [3] respectively. The other relays are left alone.
- R6: Codes 0x05, 0x06, 0x07 and 0x08 clear relay_o[0], [1], [2] and [3] respectively. The other relays are left alone.
- R7: Any other accepted code, including 0x00 and every value above 0x08, still pulses strobe_o but changes no relay.
- R8: A low level on sw_ni[k] inverts relay_o[k]. The inversion appears at the third rising edge after the input is driven low.
- R9: After a local inversion, the switches are ignored for LOCK = CLK_HZ/LOCK_DIV cycles, which is 0.5 s with the default LOCK_DIV of 2. A switch held closed therefore inverts its relay once every LOCK cycles.
- R10: When more than one switch is closed, only the lowest-numbered one is acted on in that pass.
- R11: If a received byte and a switch inversion fall due on the same edge, the byte is applied. The switch is reconsidered on the following edge, and the lockout timer is not restarted at the collision edge.
- R12: While rst_ni is low, every relay is off and strobe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial command line, idle high |
| sw_ni | input | N_RELAY | Local switches, active low, bit k serves relay k |
| relay_o | output | N_RELAY | Relay drive bits, 1 = energised |
| strobe_o | output | 1 | One-cycle pulse per accepted byte |

## Verification
The collision case arises when a switch's lockout runs out on the same edge that a decoded byte is applied. The bench creates it on purpose. It closes switch 0, waits exactly as many cycles as place the end of the lockout on the byte's apply edge, and then sends a clear command for that relay while the switch is still held. A behavioural model runs every clock and applies the byte first and the inversion one edge later. The outputs are compared with this model every cycle, and the final relay level is checked explicitly.

// File: rtl/relay_link_pkg.sv
package relay_link_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned OVS_DEF = 16;
endpackage

// File: rtl/serial_os_rx.sv
module serial_os_rx
  import relay_link_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 1200,
  parameter int unsigned OVS    = OVS_DEF,
  parameter int unsigned DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned DIV   = CLK_HZ / (BAUD * OVS);
  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned OS_W  = $clog2(OVS);
  localparam int unsigned BIT_W = $clog2(DW);
  localparam int unsigned HALF  = OVS / 2;

  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        state_q;
  logic [DIV_W-1:0] div_q;
  logic [OS_W-1:0]  os_q;
  logic [BIT_W-1:0] bit_q;
  logic [DW-1:0]    shift_q;
  logic             tick;

  assign rx_s = sync_q[1];
  assign tick = (div_q == DIV_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      div_q   <= '0;
      os_q    <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      data_o  <= '0;
      vld_o   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      vld_o  <= 1'b0;
      if (state_q == RX_IDLE) begin
        div_q <= '0;
        os_q  <= '0;
        if (!rx_s) state_q <= RX_START;
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) os_q <= os_q + 1'b1;
        unique case (state_q)
          RX_START: if (tick && os_q == OS_W'(HALF - 1)) begin
            if (rx_s) state_q <= RX_IDLE;   // glitch, not a start bit
            else begin
              state_q <= RX_DATA;
              os_q    <= '0;
              bit_q   <= '0;
            end
          end
          RX_DATA: if (tick && os_q == OS_W'(OVS - 1)) begin
            shift_q <= {rx_s, shift_q[DW-1:1]};
            os_q    <= '0;
            if (bit_q == BIT_W'(DW - 1)) state_q <= RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end
          RX_STOP: if (tick && os_q == OS_W'(OVS - 1)) begin
            if (rx_s) begin
              vld_o  <= 1'b1;
              data_o <= shift_q;
            end
            state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R4: one byte, one single-cycle strobe
  a_r4_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

  // R3: a low stop sample yields no strobe
  a_r3_bad_stop_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_STOP && tick && os_q == OS_W'(OVS - 1) && !rx_s) |=> !vld_o);
endmodule

// File: rtl/local_switch_scan.sv
module local_switch_scan #(
  parameter int unsigned N        = 4,
  parameter int unsigned LOCK_CYC = 25_000_000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sw_ni,
  input  logic         hold_i,
  output logic [N-1:0] tog_o
);
  localparam int unsigned LCK_W = $clog2(LOCK_CYC + 1);

  logic [N-1:0]     sw_m_q, sw_s_q;
  logic [N-1:0]     closed, lowest;
  logic [LCK_W-1:0] lock_q;

  assign closed = ~sw_s_q;
  assign lowest = closed & (~closed + {{(N-1){1'b0}}, 1'b1});
  assign tog_o  = (lock_q == '0 && !hold_i) ? lowest : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_m_q <= '1;
      sw_s_q <= '1;
      lock_q <= '0;
    end else begin
      sw_m_q <= sw_ni;
      sw_s_q <= sw_m_q;
      if (|tog_o)            lock_q <= LCK_W'(LOCK_CYC - 1);
      else if (lock_q != '0) lock_q <= lock_q - 1'b1;
    end
  end

  // R10: at most one relay served per pass
  a_r10_single_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tog_o));

  // R9: an inversion opens a quiet window
  a_r9_lockout_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tog_o) |=> (tog_o == '0));
endmodule

// File: rtl/relay_link_ctrl.sv
module relay_link_ctrl #(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned BAUD     = 1200,
  parameter int unsigned LOCK_DIV = 2,
  parameter int unsigned N_RELAY  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_i,
  input  logic [N_RELAY-1:0] sw_ni,
  output logic [N_RELAY-1:0] relay_o,
  output logic               strobe_o
);
  localparam int unsigned LOCK_CYC = CLK_HZ / LOCK_DIV;

  logic               rx_vld;
  logic [7:0]         rx_data;
  logic [N_RELAY-1:0] tog, set_m, clr_m, relay_q;

  serial_os_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(relay_link_pkg::OVS_DEF), .DW(8)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .vld_o (rx_vld),
    .data_o(rx_data)
  );

  local_switch_scan #(.N(N_RELAY), .LOCK_CYC(LOCK_CYC)) u_scan (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sw_ni (sw_ni),
    .hold_i(rx_vld),
    .tog_o (tog)
  );

  for (genvar g = 0; g < N_RELAY; g++) begin : g_dec
    assign set_m[g] = (rx_data == 8'(g + 1));
    assign clr_m[g] = (rx_data == 8'(g + 1 + N_RELAY));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     relay_q <= '0;
    else if (rx_vld) relay_q <= (relay_q | set_m) & ~clr_m;
    else             relay_q <= relay_q ^ tog;
  end

  assign relay_o  = relay_q;
  assign strobe_o = rx_vld;

  // R11: a received byte shuts out the switch path that cycle
  a_r11_rx_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld |-> (tog == '0));

  // R5: on-codes land
  a_r5_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld |=> ((relay_q & $past(set_m)) == $past(set_m)));

  // R6: off-codes land
  a_r6_clear_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld |=> ((relay_q & $past(clr_m)) == '0));

  // R7: unmapped codes leave relays alone
  a_r7_unmapped_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld && set_m == '0 && clr_m == '0) |=> (relay_q == $past(relay_q)));
endmodule

// File: tb/relay_link_ctrl_bench.sv
module relay_link_ctrl_bench;
  localparam int unsigned CLK_HZ   = 192_000;
  localparam int unsigned BAUD     = 1200;
  localparam int unsigned LOCK_DIV = 100;
  localparam int D    = CLK_HZ / (BAUD * 16);   // 10
  localparam int LOCK = CLK_HZ / LOCK_DIV;      // 1920
  localparam int LAT  = 152 * D + 4;

  logic       clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic [3:0] sw_n = 4'hF, relay;
  logic       strobe;

  relay_link_ctrl #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .LOCK_DIV(LOCK_DIV), .N_RELAY(4)) u_relay_link_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .sw_ni(sw_n), .relay_o(relay), .strobe_o(strobe)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, n_stb = 0, exp_stb = 0;
  string cur_req = "R12";
  bit done = 1'b0;

  // behavioural reference
  logic [3:0] m_relay = '0, d1 = '1, d2 = '1;
  logic       m_stb = 1'b0;
  int         lock = 0;
  int         pend_t[$];
  logic [7:0] pend_c[$];

  always @(posedge clk) begin
    logic [3:0] closed;
    logic [7:0] c;
    bit hit;
    cyc++;
    if (!rst_n) begin
      m_relay = '0; d1 = '1; d2 = '1; lock = 0; m_stb = 1'b0;
    end else begin
      closed = ~d2; d2 = d1; d1 = sw_n;
      hit = 1'b0;
      if (pend_t.size() > 0 && pend_t[0] == cyc) begin
        c = pend_c[0];
        void'(pend_t.pop_front());
        void'(pend_c.pop_front());
        hit = 1'b1;
        if (c >= 8'd1 && c <= 8'd4) m_relay[c-1] = 1'b1;
        else if (c >= 8'd5 && c <= 8'd8) m_relay[c-5] = 1'b0;
      end
      if (!hit && lock == 0 && closed != 0) begin
        for (int i = 0; i < 4; i++)
          if (closed[i]) begin m_relay[i] = ~m_relay[i]; break; end
        lock = LOCK - 1;
      end else if (lock > 0) lock--;
      m_stb = (pend_t.size() > 0 && pend_t[0] == cyc + 1);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (relay !== m_relay || strobe !== m_stb) begin
        n_bad++;
        $display("FAIL %s cyc=%0d relay=%b strobe=%b expected relay=%b strobe=%b",
                 cur_req, cyc, relay, strobe, m_relay, m_stb);
      end
      if (strobe === 1'b1) n_stb++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; leaves at a falling edge
  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    if (stop_ok) begin
      pend_t.push_back(cyc + LAT);
      pend_c.push_back(b);
      exp_stb++;
    end
    rx = 1'b0;
    repeat (16 * D) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (16 * D) @(negedge clk);
    end
    rx = stop_ok;
    repeat (16 * D) @(negedge clk);
    if (!stop_ok) begin
      rx = 1'b1;
      repeat (32 * D) @(negedge clk);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(relay == 4'h0 && strobe == 1'b0, "R12", {relay, 3'b0, strobe}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    cur_req = "R5";
    send_byte(8'h01, 1); send_byte(8'h02, 1); send_byte(8'h03, 1); send_byte(8'h04, 1);
    chk(relay == 4'hF, "R5", relay, 4'hF);

    cur_req = "R6";
    send_byte(8'h06, 1); send_byte(8'h08, 1);
    chk(relay == 4'b0101, "R6", relay, 4'b0101);

    cur_req = "R7";
    send_byte(8'h00, 1); send_byte(8'h09, 1); send_byte(8'hFF, 1); send_byte(8'h41, 1);
    chk(relay == 4'b0101, "R7", relay, 4'b0101);
    chk(n_stb == exp_stb, "R7", n_stb, exp_stb);

    cur_req = "R1";
    send_byte(8'h05, 1); send_byte(8'h07, 1); send_byte(8'h02, 1);
    chk(relay == 4'b0010, "R1", relay, 4'b0010);

    cur_req = "R3";
    send_byte(8'h03, 0);
    chk(relay == 4'b0010, "R3", relay, 4'b0010);
    chk(n_stb == exp_stb, "R3", n_stb, exp_stb);

    cur_req = "R2";
    rx = 1'b0; repeat (3 * D) @(negedge clk);
    rx = 1'b1; repeat (20 * D) @(negedge clk);
    chk(n_stb == exp_stb, "R2", n_stb, exp_stb);

    cur_req = "R4";
    send_byte(8'h04, 1);
    chk(n_stb == exp_stb, "R4", n_stb, exp_stb);

    cur_req = "R8";
    sw_n = 4'b1011; repeat (5) @(negedge clk);
    sw_n = 4'hF;    repeat (10) @(negedge clk);
    chk(relay == 4'b1110, "R8", relay, 4'b1110);
    repeat (LOCK) @(negedge clk);

    cur_req = "R10";
    sw_n = 4'b0101; repeat (5) @(negedge clk);
    sw_n = 4'hF;    repeat (10) @(negedge clk);
    chk(relay == 4'b1100, "R10", relay, 4'b1100);
    repeat (LOCK) @(negedge clk);

    cur_req = "R9";
    sw_n = 4'b1110; repeat (2 * LOCK + 50) @(negedge clk);
    sw_n = 4'hF;    repeat (50) @(negedge clk);
    chk(relay == 4'b1101, "R9", relay, 4'b1101);
    sw_n = 4'b0111; repeat (5) @(negedge clk);
    sw_n = 4'hF;    repeat (20) @(negedge clk);
    chk(relay == 4'b1101, "R9", relay, 4'b1101);
    repeat (LOCK + 20) @(negedge clk);

    cur_req = "R11";
    sw_n = 4'b1110;
    repeat (399) @(negedge clk);
    send_byte(8'h05, 1);
    sw_n = 4'hF;
    repeat (20) @(negedge clk);
    chk(relay[0] == 1'b1, "R11", relay[0], 1);
    repeat (LOCK + 20) @(negedge clk);
    chk(n_stb == exp_stb, "R4", n_stb, exp_stb);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule